// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Shadowed Settings

The block drives several independent pulse outputs from one clock. Each channel counts up through a programmable span, enters its active phase when the count reaches a start value, and returns to its inactive phase when the count reaches a toggle value. The output level in each phase is selected by software: driven high, driven low, or released. A released output is shown as a deasserted output-enable. A per-channel prescaler slows the count with one of eight divide ratios. These ratios are not evenly spaced.

Software reaches the block through a word-addressed register port. A shared enable register sits at offset 0x0, with a set alias at 0x4 and a clear alias at 0x8. Each channel has a timing-window register at 0x10 + 0x20·n and a span/level register at 0x20 + 0x20·n. Software writes the window register first and the span register second. Writing the span register arms a transfer of both live registers into the channel's working copy. That transfer happens only when the channel's count wraps, so a running waveform never shows a shortened pulse.

Top module: `pwm_multi`

## Requirements
- R1: Register reads have one cycle of latency and return the live (most recently written) values. A window register reads as {toggle[31:16], start[15:0]}. A span/level register reads as {9'b0, prescale[22:20], idle_level[19:18], busy_level[17:16], span[15:0]}, so bits 31:23 always read 0. An address that matches no register reads 0.
- R2: A write to 0x0 loads the enable bits. A write to 0x4 sets only the bits written as 1, and a write to 0x8 clears only the bits written as 1. Bit n enables channel n, and all three addresses read back the current enable value.
- R3: A prescale code p of 0..7 advances the count once every 2^s clocks, with s = 1st..8th entry of {0,1,2,3,4,6,8,10}.
- R4: An enabled channel counts 0,1,…,span and then wraps to 0. One period therefore lasts 2^s·(span+1) clocks, with exactly one rising output edge per period when the window is neither empty nor full.
- R5: The channel is in its busy phase while start ≤ count < toggle and in its idle phase otherwise.
- R6: A level code of 3 drives 1 and a code of 2 drives 0, each with the output enable asserted. A code of 0 or 1 deasserts the output enable and holds the output at 0. Busy and idle phases each have their own code.
- R7: Writing only the window register does not change the waveform.
- R8: While a channel is enabled, armed settings take effect only at the clock where the count wraps from span to 0, so no pulse of an intermediate length appears.
- R9: A disabled channel holds its count and prescaler at 0, drives its committed idle level, and commits armed settings on the next clock. On enable it starts a fresh period at count 0.
- R10: The outputs are registered and lag the count by one clock. After reset, every register reads 0 and every output and output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| pwm_out | output | NCH | Output level per channel |
| pwm_oe | output | NCH | Output enable per channel |

## Verification
The assertions assume that addresses are word aligned and that at most one register access is issued per clock. The stimulus follows the intended programming order, window register before span register, so pending settings always form a consistent pair. The bench also keeps start and toggle within 0..span+2. Under these conditions the count can never exceed the committed span, and a committed change can be tied to a wrap or to the disabled state.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 16;
  localparam int PRE_W     = 10;
  localparam int OFS_EN    = 'h00;
  localparam int OFS_SET   = 'h04;
  localparam int OFS_CLR   = 'h08;
  localparam int BANK_BASE = 'h10;
  localparam int BANK_STEP = 'h20;

  typedef enum logic [1:0] {
    LVL_REL0 = 2'd0,
    LVL_REL1 = 2'd1,
    LVL_LOW  = 2'd2,
    LVL_HIGH = 2'd3
  } lvl_e;

  typedef struct packed {
    logic [CNT_W-1:0] toggle;
    logic [CNT_W-1:0] start;
  } win_cfg_t;

  typedef struct packed {
    logic [2:0]       prescale;
    lvl_e             idle_lvl;
    lvl_e             busy_lvl;
    logic [CNT_W-1:0] span;
  } span_cfg_t;

  localparam int SPAN_BITS = $bits(span_cfg_t);

  // non-uniform divide exponents: 0,1,2,3,4 then steps of two
  function automatic int unsigned div_shift(input logic [2:0] code);
    return (code < 3'd5) ? int'(code) : (2 * int'(code) - 4);
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_multi_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic [NCH-1:0]         ctrl_q,
  output win_cfg_t  [NCH-1:0]    win_live,
  output span_cfg_t [NCH-1:0]    span_live,
  output logic [NCH-1:0]         span_wr
);
  localparam int IDX_W = ADDR_W - 5;

  logic [ADDR_W-1:0] rel;
  logic              in_bank;
  logic [IDX_W-1:0]  ch_sel;
  logic              is_win;
  logic              is_span;
  logic [DATA_W-1:0] rd_next;

  assign rel     = addr - ADDR_W'(BANK_BASE);
  assign in_bank = (addr >= ADDR_W'(BANK_BASE));
  assign ch_sel  = rel[ADDR_W-1:5];
  assign is_win  = (rel[4:0] == 5'h00);
  assign is_span = (rel[4:0] == 5'h10);

  for (genvar i = 0; i < NCH; i++) begin : g_live
    logic hit_win;
    logic hit_span;
    assign hit_win    = we && in_bank && is_win  && (ch_sel == IDX_W'(i));
    assign hit_span   = we && in_bank && is_span && (ch_sel == IDX_W'(i));
    assign span_wr[i] = hit_span;

    always_ff @(posedge clk) begin
      if (rst) begin
        win_live[i]  <= '0;
        span_live[i] <= '0;
      end else begin
        if (hit_win)  win_live[i]  <= win_cfg_t'(wdata);
        if (hit_span) span_live[i] <= span_cfg_t'(wdata[SPAN_BITS-1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(OFS_EN))       ctrl_q <= wdata[NCH-1:0];
      else if (addr == ADDR_W'(OFS_SET)) ctrl_q <= ctrl_q | wdata[NCH-1:0];
      else if (addr == ADDR_W'(OFS_CLR)) ctrl_q <= ctrl_q & ~wdata[NCH-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(OFS_EN) || addr == ADDR_W'(OFS_SET) || addr == ADDR_W'(OFS_CLR)) begin
      rd_next = DATA_W'(ctrl_q);
    end else if (in_bank) begin
      for (int i = 0; i < NCH; i++) begin
        if (ch_sel == IDX_W'(i)) begin
          if (is_win)       rd_next = DATA_W'(win_live[i]);
          else if (is_span) rd_next = DATA_W'(span_live[i]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_multi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  win_cfg_t         win_live,
  input  span_cfg_t        span_live,
  input  logic             span_wr,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] span_o,
  output logic             pwm_out,
  output logic             pwm_oe
);
  win_cfg_t         win_c;
  span_cfg_t        span_c;
  logic             armed;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_lim;
  logic             tick;
  logic             wrap;
  logic             commit;
  logic             busy;
  lvl_e             lvl;

  always_comb begin
    pre_lim = PRE_W'((32'd1 << div_shift(span_c.prescale)) - 32'd1);
    tick    = en && (pre_q == pre_lim);
    wrap    = tick && (cnt_q == span_c.span);
    commit  = armed && (!en || wrap);
    busy    = en && (cnt_q >= win_c.start) && (cnt_q < win_c.toggle);
    lvl     = busy ? span_c.busy_lvl : span_c.idle_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_c   <= '0;
      span_c  <= '0;
      armed   <= 1'b0;
      pre_q   <= '0;
      cnt_q   <= '0;
      pwm_out <= 1'b0;
      pwm_oe  <= 1'b0;
    end else begin
      if (commit) begin
        win_c  <= win_live;
        span_c <= span_live;
      end
      armed <= span_wr | (armed & ~commit);
      if (!en) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        pre_q <= '0;
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
      pwm_oe  <= lvl[1];
      pwm_out <= lvl[1] & lvl[0];
    end
  end

  assign cnt_o  = cnt_q;
  assign span_o = span_c.span;
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_multi_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    pwm_oe
);
  logic [NCH-1:0]              ctrl_q;
  win_cfg_t  [NCH-1:0]         win_live;
  span_cfg_t [NCH-1:0]         span_live;
  logic [NCH-1:0]              span_wr;
  logic [NCH-1:0][CNT_W-1:0]   chan_cnt;
  logic [NCH-1:0][CNT_W-1:0]   chan_span;

  pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (bus_we),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .ctrl_q    (ctrl_q),
    .win_live  (win_live),
    .span_live (span_live),
    .span_wr   (span_wr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_chan u_chan (
      .clk       (clk),
      .rst       (rst),
      .en        (ctrl_q[i]),
      .win_live  (win_live[i]),
      .span_live (span_live[i]),
      .span_wr   (span_wr[i]),
      .cnt_o     (chan_cnt[i]),
      .span_o    (chan_span[i]),
      .pwm_out   (pwm_out[i]),
      .pwm_oe    (pwm_oe[i])
    );
  end
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk
  import pwm_multi_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_we,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [31:0]               bus_wdata,
  input logic [NCH-1:0]            ctrl_q,
  input logic [NCH-1:0][CNT_W-1:0] chan_cnt,
  input logic [NCH-1:0][CNT_W-1:0] chan_span,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0]            pwm_oe
);
  // R2
  set_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_SET)) |=>
      ((ctrl_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  // R2
  clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_CLR)) |=>
      ((ctrl_q & $past(bus_wdata[NCH-1:0])) == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      chan_cnt[i] <= chan_span[i]);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ctrl_q[i] |=> (chan_cnt[i] == '0));

    // R8
    commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
      (chan_span[i] != $past(chan_span[i])) |->
        ($past(!ctrl_q[i]) || ($past(chan_cnt[i]) == $past(chan_span[i]))));

    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !pwm_oe[i] |-> !pwm_out[i]);
  end
endmodule

bind pwm_multi pwm_multi_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ctrl_q    (ctrl_q),
  .chan_cnt  (chan_cnt),
  .chan_span (chan_span),
  .pwm_out   (pwm_out),
  .pwm_oe    (pwm_oe)
);

// File: tb/pwm_multi_tb.sv
module pwm_multi_tb;
  localparam int NCH    = 4;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    pwm_out;
  logic [NCH-1:0]    pwm_oe;

  int errors = 0;
  int checks = 0;

  // R8 pulse monitor state
  logic watch = 1'b0;
  int   run_len = 0;
  int   bad_runs = 0;

  always #5 clk = ~clk;

  pwm_multi #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  function automatic logic [7:0] a_win(int ch);  return 8'(16 + 32 * ch); endfunction
  function automatic logic [7:0] a_span(int ch); return 8'(32 + 32 * ch); endfunction
  function automatic logic [31:0] span_word(int span, int pre, int busy, int idle);
    return (32'(pre) << 20) | (32'(idle) << 18) | (32'(busy) << 16) | 32'(span);
  endfunction
  function automatic int shift_of(int pre); return (pre < 5) ? pre : 2 * pre - 4; endfunction

  // count per period of clocks at a given code class: want 0 = driven high, 1 = oe high
  function automatic int per_period(int span, int start, int toggle, int busy, int idle, int want);
    int n = 0;
    for (int k = 0; k <= span; k++) begin
      int code = (k >= start && k < toggle) ? busy : idle;
      if (want == 0 && code == 3) n++;
      if (want == 1 && code >= 2) n++;
    end
    return n;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic measure(input int ch, input int n, output int highs, output int oes, output int rises);
    logic prev;
    highs = 0; oes = 0; rises = 0;
    @(negedge clk);
    prev = pwm_out[ch];
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (pwm_out[ch]) highs++;
      if (pwm_oe[ch]) oes++;
      if (pwm_out[ch] && !prev) rises++;
      prev = pwm_out[ch];
    end
  endtask

  task automatic setup(input int ch, input int span, input int start, input int toggle,
                       input int pre, input int busy, input int idle);
    wr(8'h08, 32'(1) << ch);
    wr(a_win(ch), (32'(toggle) << 16) | 32'(start));
    wr(a_span(ch), span_word(span, pre, busy, idle));
    repeat (2) @(negedge clk);
    wr(8'h04, 32'(1) << ch);
    repeat ((1 << shift_of(pre)) * (span + 1) + 4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (watch) begin
      if (pwm_out[0]) run_len++;
      else if (run_len > 0) begin
        if (run_len != 4 && run_len != 1) bad_runs++;
        run_len = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int h, o, r, dv, exp_h;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    rd(8'h00, d);       check(d == 0, "R10 enable reg after reset", d, 0);
    rd(a_span(1), d);   check(d == 0, "R10 span reg after reset", d, 0);
    check(pwm_oe == 0,  "R10 oe after reset", pwm_oe, 0);
    check(pwm_out == 0, "R10 out after reset", pwm_out, 0);

    // R1 readback and masking
    wr(a_win(3), 32'hABCD_1234);
    rd(a_win(3), d);  check(d == 32'hABCD_1234, "R1 window readback", d, 32'hABCD_1234);
    wr(a_span(3), 32'hFFFF_FFFF);
    rd(a_span(3), d); check(d == 32'h007F_FFFF, "R1 span readback masked", d, 32'h007F_FFFF);
    rd(8'h0C, d);     check(d == 0, "R1 unmapped reads zero", d, 0);
    rd(8'h90, d);     check(d == 0, "R1 channel beyond NCH reads zero", d, 0);

    // R2 enable register and aliases
    wr(8'h00, 32'h5); rd(8'h00, d); check(d == 5, "R2 direct write", d, 5);
    wr(8'h04, 32'h2); rd(8'h04, d); check(d == 7, "R2 set alias", d, 7);
    wr(8'h08, 32'h5); rd(8'h08, d); check(d == 2, "R2 clear alias", d, 2);
    wr(8'h08, 32'h0); rd(8'h00, d); check(d == 2, "R2 clear of zero bits", d, 2);
    wr(8'h00, 32'h0);

    // R3 R4 prescaler sweep: span 3, window [1,3), normal levels
    for (int p = 0; p < 8; p++) begin
      dv = 1 << shift_of(p);
      setup(0, 3, 1, 3, p, 3, 2);
      measure(0, 8 * dv, h, o, r);
      check(h == 4 * dv, $sformatf("R3 high clocks prescale %0d", p), h, 4 * dv);
      check(r == 2, $sformatf("R4 edges in two periods prescale %0d", p), r, 2);
    end
    // R6 inverse polarity
    setup(0, 3, 1, 3, 2, 2, 3);
    measure(0, 32, h, o, r);
    check(h == 16, "R6 inverse polarity highs", h, 16);
    check(o == 32, "R6 inverse polarity oe", o, 32);

    // R5 window sweep on channel 1, span 5, undivided
    for (int s = 0; s <= 6; s++) begin
      for (int t = 0; t <= 7; t++) begin
        setup(1, 5, s, t, 0, 3, 2);
        measure(1, 12, h, o, r);
        exp_h = 2 * per_period(5, s, t, 3, 2, 0);
        check(h == exp_h, $sformatf("R5 window start=%0d toggle=%0d", s, t), h, exp_h);
      end
    end

    // R6 released levels
    setup(2, 3, 0, 2, 0, 0, 3);
    measure(2, 8, h, o, r);
    check(o == 4, "R6 busy released oe", o, 4);
    check(h == 4, "R6 busy released out", h, 4);
    setup(2, 3, 0, 2, 0, 2, 1);
    measure(2, 8, h, o, r);
    check(o == 4, "R6 idle released oe", o, 4);
    check(h == 0, "R6 idle released out", h, 0);

    // R9 disabled channel drives idle level, then fresh period
    wr(8'h08, 32'h8);
    wr(a_win(3), (32'd2 << 16) | 32'd0);
    wr(a_span(3), span_word(3, 0, 2, 3));
    repeat (3) @(negedge clk);
    measure(3, 20, h, o, r);
    check(h == 20 && o == 20, "R9 disabled holds idle high", h, 20);
    wr(8'h04, 32'h8);
    @(negedge clk); check(pwm_out[3] == 0, "R9 fresh period count0", pwm_out[3], 0);
    @(negedge clk); check(pwm_out[3] == 0, "R9 fresh period count1", pwm_out[3], 0);
    @(negedge clk); check(pwm_out[3] == 1, "R9 fresh period count2", pwm_out[3], 1);
    @(negedge clk); check(pwm_out[3] == 1, "R9 fresh period count3", pwm_out[3], 1);

    // R7 R8 shadowed update on channel 0: span 7, window [0,4)
    setup(0, 7, 0, 4, 0, 3, 2);
    wr(a_win(0), (32'd1 << 16) | 32'd0);
    repeat (20) @(negedge clk);
    measure(0, 16, h, o, r);
    check(h == 8, "R7 window write alone keeps waveform", h, 8);
    rd(a_win(0), d); check(d == 32'h0001_0000, "R1 read returns live window", d, 32'h0001_0000);
    while (pwm_out[0]) @(negedge clk);
    watch = 1'b1;
    while (!pwm_out[0]) @(negedge clk);
    @(negedge clk);
    wr(a_span(0), span_word(7, 0, 3, 2));
    repeat (30) @(negedge clk);
    watch = 1'b0;
    check(bad_runs == 0, "R8 no pulse of intermediate length", bad_runs, 0);
    measure(0, 16, h, o, r);
    check(h == 2, "R8 new window after wrap", h, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule